// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches sixteen maskable external interrupt lines and one nonmaskable line. It turns pin activity into latched request flags. Each maskable line has its own sense mode: low level, falling edge, rising edge or both edges. Lines 15 down to 2 can each take their input from either a primary pin or an alternate pin. Lines 1 and 0 are wired to their primary pins only. Every pin passes through a two-stage synchronizer before any edge or level is judged.

Software programs the block through a small register port. The port gives access to:
- the sense modes
- the per-line enables
- the per-line status flags
- the pin selects
- the polarity of the nonmaskable edge

A status flag is set by its line's event, whether or not the line is enabled. Software clears a flag by first reading it as 1 and then writing 0 to it. The maskable request output is raised while any enabled line has its flag set. The nonmaskable request is a one-cycle pulse that cannot be masked.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every register reads 0, `irq_req` is low and `nmi_req` is low. The reset values are:
  - all lines in low-level mode
  - all lines disabled
  - all lines on their primary pins
  - the nonmaskable edge set to falling
- R2: Sense code 01 selects falling edge. A high-to-low change on a line's selected pin sets that line's status bit. The bit can first be seen after the third rising clock edge that follows the pin change.
- R3: Sense code 10 selects rising edge. A low-to-high change sets the status bit with the same three-edge latency. A high-to-low change has no effect.
- R4: Sense code 11 selects both edges. Either direction of change sets the status bit with the same three-edge latency.
- R5: Sense code 00 selects low level. The status bit is set while the synchronized pin is low, and a clear attempt has no effect during that time. The bit stays set after the pin returns high, until it is cleared.
- R6: Select bit n (n from 2 to 15) chooses the line's pin. A value of 1 routes the alternate pin `irq_alt_pin[n-2]` to line n; a value of 0 routes primary pin `irq_pin[n]`. The pin that is not selected has no effect. Select bits 1 and 0 ignore writes and read 0.
- R7: `irq_req` is the OR over all lines of (status AND enable). The enable bit does not prevent the status bit from being set. A change to the enable register shows on `irq_req` one cycle after the write.
- R8: Writing 0 to a status bit clears it only if the bit has been read as 1 at the status address since it was last set or last cleared. Writing 1 leaves the bit unchanged. A new event in the same cycle as a clear keeps the bit set.
- R9: Nonmaskable edge control bit 0 selects the edge: 1 means rising and 0 means falling. On the selected edge of `nmi_pin`, `nmi_req` goes high for exactly one cycle, after the third rising clock edge. It has no enable.
- R10: A write that changes a line's sense code or pin select suppresses edge detection for that line in the following cycle. As a result, switching the select from a high pin to a low pin does not record a falling edge.
- R11: The register addresses are:

  | Address | Contents |
  |---|---|
  | 0 | Sense codes of lines 0–7; line i uses bits 2i+1:2i |
  | 1 | Sense codes of lines 8–15; line i uses bits 2(i-8)+1:2(i-8) |
  | 2 | Enable |
  | 3 | Status |
  | 4 | Pin select |
  | 5 | Nonmaskable edge control, bit 0 |
  | others | Read 0 |

  Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 16 | Primary pins of lines 15..0 |
| irq_alt_pin | input | 14 | Alternate pins; bit j feeds line j+2 |
| nmi_pin | input | 1 | Nonmaskable interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms status bits for clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| irq_req | output | 1 | Combined maskable request |
| nmi_req | output | 1 | Nonmaskable request pulse |

## Verification
A pin change driven between two clock edges has a fixed latency. It reaches a status bit, `irq_req` or `nmi_req` only after the third following rising edge. Directed checks therefore sample low after two edges and high after three.

Register writes take effect one edge after the strobe, and reads are sampled in the same cycle as the address is driven. Every other output is compared on each falling edge against a behavioural model. The model shifts pin samples through its own delay variables and applies the arming and clearing rules exactly as the requirements state them.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_FALL = 2'b01,
        SNS_RISE = 2'b10,
        SNS_BOTH = 2'b11
    } sense_e;

    localparam int unsigned ADR_MODE_LO = 0;
    localparam int unsigned ADR_MODE_HI = 1;
    localparam int unsigned ADR_ENABLE  = 2;
    localparam int unsigned ADR_STATUS  = 3;
    localparam int unsigned ADR_PINSEL  = 4;
    localparam int unsigned ADR_NMICTL  = 5;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    // Idle-high lines: reset to ones so no edge is seen after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/eirq_line.sv
module eirq_line
    import eirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   level_i,
    input  sense_e mode_i,
    input  logic   restart_i,
    output logic   hit_o
);
    typedef struct packed {
        logic prev;
        logic live;
    } line_t;

    line_t st_d, st_q;
    logic  fell, rose;

    always_comb begin
        st_d.prev = level_i;
        st_d.live = !restart_i;
        fell = st_q.live && st_q.prev && !level_i;
        rose = st_q.live && !st_q.prev && level_i;
        case (mode_i)
            SNS_LOW:  hit_o = !level_i;
            SNS_FALL: hit_o = fell;
            SNS_RISE: hit_o = rose;
            default:  hit_o = fell | rose;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, live: 1'b1};
        else        st_q <= st_d;
    end

    AST_QUIET_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(restart_i) && mode_i != SNS_LOW) |-> !hit_o); // R10
endmodule

// File: rtl/eirq_nmi.sv
module eirq_nmi (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_sel_i,
    output logic nmi_o
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } nmi_t;

    nmi_t st_d, st_q;

    always_comb begin
        st_d.prev  = level_i;
        st_d.pulse = (level_i != st_q.prev) && (level_i == rise_sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign nmi_o = st_q.pulse;

    AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_o |=> !nmi_o); // R9
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eirq_pkg::*;
#(
    parameter int unsigned NUM_IRQ   = 16,
    parameter int unsigned FIRST_ALT = 2,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IRQ-1:0]             irq_pin,
    input  logic [NUM_IRQ-FIRST_ALT-1:0]   irq_alt_pin,
    input  logic                           nmi_pin,
    input  logic                           reg_wr,
    input  logic                           reg_rd,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [NUM_IRQ-1:0]             reg_wdata,
    output logic [NUM_IRQ-1:0]             reg_rdata,
    output logic                           irq_req,
    output logic                           nmi_req
);
    localparam int unsigned NUM_ALT = NUM_IRQ - FIRST_ALT;
    localparam int unsigned MODE_W  = 2 * NUM_IRQ;
    localparam logic [NUM_IRQ-1:0] SEL_MASK = {{NUM_ALT{1'b1}}, {FIRST_ALT{1'b0}}};

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [NUM_IRQ-1:0] en;
        logic [NUM_IRQ-1:0] stat;
        logic [NUM_IRQ-1:0] armed;
        logic [NUM_IRQ-1:0] sel;
        logic               nmi_rise;
    } reg_t;

    reg_t st_d, st_q;

    logic [NUM_IRQ-1:0] pri_s, cur, hit, restart, clr_try, arm_new;
    logic [NUM_ALT-1:0] alt_s;
    logic               nmi_s;
    logic               wr_stat, rd_stat;

    eirq_sync #(.WIDTH(NUM_IRQ)) u_sync_pri (
        .clk(clk), .rst_n(rst_n), .async_i(irq_pin), .sync_o(pri_s));
    eirq_sync #(.WIDTH(NUM_ALT)) u_sync_alt (
        .clk(clk), .rst_n(rst_n), .async_i(irq_alt_pin), .sync_o(alt_s));
    eirq_sync #(.WIDTH(1)) u_sync_nmi (
        .clk(clk), .rst_n(rst_n), .async_i(nmi_pin), .sync_o(nmi_s));

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        if (i >= FIRST_ALT) begin : g_alt
            assign cur[i] = st_q.sel[i] ? alt_s[i-FIRST_ALT] : pri_s[i];
        end else begin : g_fix
            assign cur[i] = pri_s[i];
        end

        eirq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .level_i   (cur[i]),
            .mode_i    (sense_e'(st_q.mode[2*i +: 2])),
            .restart_i (restart[i]),
            .hit_o     (hit[i])
        );

        AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> st_q.stat[i]); // R2
        AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.mode[2*i +: 2] == SNS_LOW && !cur[i]) |=> st_q.stat[i]); // R5
        AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.stat[i]) |-> $past(wr_stat && !reg_wdata[i] && st_q.armed[i])); // R8
    end

    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(ADR_STATUS));
    assign rd_stat = reg_rd && (reg_addr == ADDR_W'(ADR_STATUS));

    always_comb begin
        st_d    = st_q;
        clr_try = {NUM_IRQ{wr_stat}} & ~reg_wdata & st_q.armed;
        arm_new = {NUM_IRQ{rd_stat}} & st_q.stat;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_W'(ADR_MODE_LO): st_d.mode[NUM_IRQ-1:0]      = reg_wdata;
                ADDR_W'(ADR_MODE_HI): st_d.mode[MODE_W-1:NUM_IRQ] = reg_wdata;
                ADDR_W'(ADR_ENABLE):  st_d.en                     = reg_wdata;
                ADDR_W'(ADR_PINSEL):  st_d.sel                    = reg_wdata & SEL_MASK;
                ADDR_W'(ADR_NMICTL):  st_d.nmi_rise               = reg_wdata[0];
                default: ;
            endcase
        end
        st_d.stat  = (st_q.stat & ~clr_try) | hit;
        st_d.armed = (st_q.armed | arm_new) & ~clr_try;
    end

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            restart[i] = (st_d.mode[2*i +: 2] != st_q.mode[2*i +: 2]) ||
                         (st_d.sel[i] != st_q.sel[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_MODE_LO): reg_rdata = st_q.mode[NUM_IRQ-1:0];
            ADDR_W'(ADR_MODE_HI): reg_rdata = st_q.mode[MODE_W-1:NUM_IRQ];
            ADDR_W'(ADR_ENABLE):  reg_rdata = st_q.en;
            ADDR_W'(ADR_STATUS):  reg_rdata = st_q.stat;
            ADDR_W'(ADR_PINSEL):  reg_rdata = st_q.sel;
            ADDR_W'(ADR_NMICTL):  reg_rdata = {{(NUM_IRQ-1){1'b0}}, st_q.nmi_rise};
            default:              reg_rdata = '0;
        endcase
    end

    assign irq_req = |(st_q.stat & st_q.en);

    eirq_nmi u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_i    (nmi_s),
        .rise_sel_i (st_q.nmi_rise),
        .nmi_o      (nmi_req)
    );

    AST_FIXED_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADR_PINSEL)) |-> (reg_rdata[FIRST_ALT-1:0] == '0)); // R6
    AST_NO_ENABLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> !irq_req); // R7
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] pri = 16'hFFFF;
    logic [13:0] alt = 14'h3FFF;
    logic        nmi = 1'b1;
    logic        wr = 0, rd = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        irq_req, nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ext_irq_sense i_ext_irq_sense (
        .clk(clk), .rst_n(rst_n), .irq_pin(pri), .irq_alt_pin(alt), .nmi_pin(nmi),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_req(irq_req), .nmi_req(nmi_req));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] mp1, mp2, m_prev, m_live, m_stat, m_arm, m_en, m_sel;
    logic [13:0] ma1, ma2;
    logic [31:0] m_mode;
    logic        mn1, mn2, m_nprev, m_nrise, m_npulse;

    always @(posedge clk or negedge rst_n) begin : model
        logic [15:0] h, clr, cv, nsel;
        logic [31:0] nmode;
        logic        c;
        int          code;
        if (!rst_n) begin
            mp1 = '1; mp2 = '1; ma1 = '1; ma2 = '1; m_prev = '1; m_live = '1;
            m_stat = 0; m_arm = 0; m_en = 0; m_sel = 0; m_mode = 0;
            mn1 = 1; mn2 = 1; m_nprev = 1; m_nrise = 0; m_npulse = 0;
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (i >= 2 && m_sel[i]) c = ma2[i-2]; else c = mp2[i];
                cv[i] = c;
                code = int'(m_mode[2*i +: 2]);
                case (code)
                    0: h[i] = !c;
                    1: h[i] = m_live[i] && m_prev[i] && !c;
                    2: h[i] = m_live[i] && !m_prev[i] && c;
                    default: h[i] = m_live[i] && (m_prev[i] != c);
                endcase
            end
            clr = (wr && addr == 3) ? (~wdata & m_arm) : 16'h0;
            if (rd && addr == 3) m_arm = m_arm | m_stat;
            m_arm  = m_arm & ~clr;
            m_stat = (m_stat & ~clr) | h;
            nmode = m_mode; nsel = m_sel;
            if (wr) begin
                if (addr == 0) nmode[15:0] = wdata;
                if (addr == 1) nmode[31:16] = wdata;
                if (addr == 2) m_en = wdata;
                if (addr == 4) nsel = wdata & 16'hFFFC;
            end
            for (int i = 0; i < 16; i++)
                m_live[i] = (nmode[2*i +: 2] == m_mode[2*i +: 2]) && (nsel[i] == m_sel[i]);
            m_prev = cv; m_mode = nmode; m_sel = nsel;
            m_npulse = (mn2 != m_nprev) && (mn2 == m_nrise);
            m_nprev = mn2;
            if (wr && addr == 5) m_nrise = wdata[0];
            mp2 = mp1; mp1 = pri; ma2 = ma1; ma1 = alt; mn2 = mn1; mn1 = nmi;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 model irq_req", {31'b0, irq_req}, {31'b0, |(m_stat & m_en)});
            chk("R9 model nmi_req", {31'b0, nmi_req}, {31'b0, m_npulse});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); rd = 1; addr = a;
        #1 chk(req, {16'b0, rdata}, {16'b0, exp});
        @(negedge clk); rd = 0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state, R11 addresses
        chk("R1 irq_req", {31'b0, irq_req}, 0);
        chk("R1 nmi_req", {31'b0, nmi_req}, 0);
        for (int a = 0; a < 8; a++) rd_reg(3'(a), 16'h0, "R1 reset read");

        // R2 falling edge on line 3
        wr_reg(0, 16'h0040);
        wr_reg(2, 16'h0008);
        @(negedge clk); pri[3] = 0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R2 not yet", {31'b0, irq_req}, 0);
        @(posedge clk); @(negedge clk);
        chk("R2 latency", {31'b0, irq_req}, 1);

        // R8 clear rule
        wr_reg(3, 16'h0000);
        rd_reg(3, 16'h0008, "R8 clear without read");
        wr_reg(3, 16'hFFFF);
        rd_reg(3, 16'h0008, "R8 write one");
        wr_reg(3, 16'hFFF7);
        chk("R8 irq dropped", {31'b0, irq_req}, 0);
        rd_reg(3, 16'h0000, "R8 cleared");

        // R3 rising edge on line 9
        wr_reg(1, 16'h0008);
        @(negedge clk); pri[9] = 0;
        wait_edges(4);
        rd_reg(3, 16'h0000, "R3 falling ignored");
        pri[9] = 1;
        wait_edges(4);
        rd_reg(3, 16'h0200, "R3 rising");
        wr_reg(3, 16'hFDFF);
        rd_reg(3, 16'h0000, "R3 cleared");

        // R4 both edges on line 5
        wr_reg(0, 16'h0C40);
        @(negedge clk); pri[5] = 0;
        wait_edges(4);
        rd_reg(3, 16'h0020, "R4 falling");
        wr_reg(3, 16'hFFDF);
        rd_reg(3, 16'h0000, "R4 cleared");
        pri[5] = 1;
        wait_edges(4);
        rd_reg(3, 16'h0020, "R4 rising");

        // R7 enable gates only the output
        chk("R7 masked", {31'b0, irq_req}, 0);
        wr_reg(2, 16'h0020);
        chk("R7 enabled", {31'b0, irq_req}, 1);
        wr_reg(3, 16'hFFDF);
        chk("R7 after clear", {31'b0, irq_req}, 0);
        rd_reg(3, 16'h0000, "R7 status");

        // R5 level on line 12
        @(negedge clk); pri[12] = 0;
        wait_edges(4);
        rd_reg(3, 16'h1000, "R5 level set");
        wr_reg(3, 16'hEFFF);
        rd_reg(3, 16'h1000, "R5 clear while low");
        pri[12] = 1;
        wait_edges(4);
        rd_reg(3, 16'h1000, "R5 sticky");
        wr_reg(3, 16'hEFFF);
        rd_reg(3, 16'h0000, "R5 cleared");

        // R6 pin select on line 4
        wr_reg(0, 16'h0D40);
        wr_reg(4, 16'h0010);
        @(negedge clk); pri[4] = 0;
        wait_edges(4);
        rd_reg(3, 16'h0000, "R6 primary ignored");
        alt[2] = 0;
        wait_edges(4);
        rd_reg(3, 16'h0010, "R6 alternate used");
        wr_reg(3, 16'hFFEF);
        rd_reg(3, 16'h0000, "R6 cleared");
        pri[4] = 1; alt[2] = 1;
        wait_edges(4);
        wr_reg(4, 16'hFFFF);
        rd_reg(4, 16'hFFFC, "R6 fixed bits");
        wait_edges(4);
        // R10 line 3: alternate high -> primary low must not log a falling edge
        wr_reg(4, 16'h0010);
        wait_edges(4);
        rd_reg(3, 16'h0000, "R10 no spurious edge");

        // R9 NMI
        @(negedge clk); nmi = 0;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R9 not yet", {31'b0, nmi_req}, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 falling pulse", {31'b0, nmi_req}, 1);
        @(posedge clk); @(negedge clk);
        chk("R9 one cycle", {31'b0, nmi_req}, 0);
        wr_reg(5, 16'h0001);
        rd_reg(5, 16'h0001, "R11 nmi ctl");
        @(negedge clk); nmi = 1;
        repeat (3) @(posedge clk); @(negedge clk);
        chk("R9 rising pulse", {31'b0, nmi_req}, 1);
        @(negedge clk); nmi = 0;
        wait_edges(4);
        chk("R9 falling ignored", {31'b0, nmi_req}, 0);

        // R11 readback
        rd_reg(0, 16'h0D40, "R11 mode lo");
        rd_reg(1, 16'h0008, "R11 mode hi");
        rd_reg(2, 16'h0020, "R11 enable");
        rd_reg(4, 16'h0010, "R11 select");
        rd_reg(6, 16'h0000, "R11 unused");

        wait_edges(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule